// File: doc/BRIEF.md
# Prioritized Interrupt Merge Unit

This block gathers interrupt requests from three timer events, two serial-channel events (receive and transmit) and five external pins. It presents one request line to a CPU core. Software sets a mask bit and a 3-bit priority for each of the seven sources. A CPU-driven global mask input can silence every maskable source at once. When the CPU acknowledges, the unit captures a vector type byte for the winning source. The timer group and the serial group each compete as a single source, but the vector tells the CPU which timer or which serial event caused the request. A non-maskable input is wired straight through and never enters the arbitration.

Source order, used for tie-breaking and for all per-source fields: 0 = timer group, 1 = serial group, 2..6 = external pins 0..4. An acknowledge sets the in-service bit of the winning source. A write of the source index to the end-of-interrupt address clears that bit. While a source is in service, every request whose priority value is equal to or worse than the in-service source's value is held off. Strictly better requests can still nest.

The control state machine has three states. **ST_IDLE** holds the request line low and moves to **ST_ASSERT** when an eligible winner exists. **ST_ASSERT** drives the request line. It moves to **ST_HOLD** when the acknowledge is seen, and back to **ST_IDLE** when the winner vanishes before an acknowledge. **ST_HOLD** is a single settling cycle after an acknowledge; it always returns to **ST_IDLE**, so the new in-service state is seen before arbitration resumes.

Top module: `pic_merge`

## Requirements
- R1: After reset the request line is low, the vector output is 0, no source is pending or in service, all seven mask bits are set and all priorities are 7.
- R2: The captured vector is 8+k for timer event k, 12 for serial receive, 13 for serial transmit, and 16+n for external pin n. An acknowledge taken while the request line is high but no source is eligible yields the spurious vector 7 and sets no in-service bit.
- R3: Write address 0, data bits [6:0], holds one mask bit per source (1 = masked). A masked source never raises the request line, but it stays visible in the pending status.
- R4: While the global mask input is high, the request line is low from the next cycle on.
- R5: Priorities live at address 1 (sources 0..4, 3 bits each from bit 0 upward) and address 2 (sources 5..6, bits [5:0]). A lower value wins; on equal values the lower source index wins.
- R6: Within the timer group the lowest-numbered pending timer event is served first; within the serial group receive is served before transmit.
- R7: An acknowledge of a real winner sets that source's in-service bit. Writing a source index in bits [2:0] to address 4 clears it.
- R8: While a source is in service, requests with an equal or larger priority value are held off, and a request with a strictly smaller value is still raised.
- R9: An external pin in level mode is pending exactly while it is high. Dropping it before the acknowledge removes the request, and holding it high after end-of-interrupt raises the request again.
- R10: Address 3 bit n set selects edge mode for pin n. A rising edge is latched and stays pending after the pin falls, the acknowledge clears it, and a pin held high does not request again.
- R11: The vector output changes only on a clock edge at which the acknowledge is high while the request line is high. An acknowledge in any other cycle has no effect.
- R12: The non-maskable output follows the non-maskable input with no clocking.
- R13: A one-cycle pulse on a timer or serial request input stays pending, even while masked, until that event is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_req_i | input | 3 | Timer event request pulses |
| ser_req_i | input | 2 | Serial event pulses, bit 0 receive, bit 1 transmit |
| ext_i | input | 5 | External interrupt pins |
| nmi_i | input | 1 | Non-maskable request in |
| gmask_i | input | 1 | Global mask from the CPU, 1 = block all |
| ack_i | input | 1 | CPU acknowledge strobe |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| irq_o | output | 1 | Merged interrupt request |
| vec_o | output | 8 | Vector type captured at acknowledge |
| nmi_o | output | 1 | Non-maskable request out |
| pend_o | output | 7 | Pending status per source |
| insvc_o | output | 7 | In-service status per source |

## Verification
The bench sweeps every pair of sources under three priority relations (better, worse, equal). It checks both the first vector and that the loser stays held off until end-of-interrupt. A design with a reversed comparison or a wrong tie-break would deliver the wrong vector, and one that ignored the in-service ceiling would raise the request again at once. Nesting, the spurious-vector race where the global mask rises in the same cycle as the acknowledge, and level against edge pins are targeted separately. A wrong race handling would set a stray in-service bit, and a pin-mode mix-up would either lose a short edge or retrigger on a held level.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NTMR  = 3;
    localparam int NSER  = 2;
    localparam int NEXT  = 5;
    localparam int NSRC  = 2 + NEXT;
    localparam int PW    = 3;
    localparam int VW    = 8;
    localparam int AW    = 3;
    localparam int DW    = 16;
    localparam int IW    = $clog2(NSRC);
    localparam int LO_N  = 5;
    localparam int HI_N  = NSRC - LO_N;

    localparam int SRC_TMR = 0;
    localparam int SRC_SER = 1;
    localparam int SRC_EXT = 2;

    localparam logic [VW-1:0] V_TMR  = 8'd8;
    localparam logic [VW-1:0] V_SER  = 8'd12;
    localparam logic [VW-1:0] V_EXT  = 8'd16;
    localparam logic [VW-1:0] V_SPUR = 8'd7;

    localparam logic [AW-1:0] A_MASK = 3'd0;
    localparam logic [AW-1:0] A_PRIL = 3'd1;
    localparam logic [AW-1:0] A_PRIH = 3'd2;
    localparam logic [AW-1:0] A_MODE = 3'd3;
    localparam logic [AW-1:0] A_EOI  = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ASSERT = 2'd1,
        ST_HOLD   = 2'd2
    } pic_state_e;
endpackage

// File: rtl/pic_pending.sv
module pic_pending #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    // A new event in the same cycle as a clear keeps the bit pending.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= set_i | (pend_o & ~clr_i);
    end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
    parameter int NS = 7,
    parameter int PW = 3,
    parameter int IW = 3
) (
    input  logic [NS-1:0]    req_i,
    input  logic [NS*PW-1:0] prio_i,
    input  logic [NS-1:0]    insvc_i,
    output logic             win_v_o,
    output logic [IW-1:0]    win_idx_o
);
    logic [PW:0]   ceil_w;
    logic [PW-1:0] best_w;
    logic [PW-1:0] p_w;

    always_comb begin
        // Best priority currently in service; PW+1 bits so "none" sits above all.
        ceil_w = {1'b1, {PW{1'b0}}};
        for (int j = 0; j < NS; j++) begin
            if (insvc_i[j] && ({1'b0, prio_i[j*PW +: PW]} < ceil_w))
                ceil_w = {1'b0, prio_i[j*PW +: PW]};
        end
        win_v_o   = 1'b0;
        win_idx_o = '0;
        best_w    = '1;
        p_w       = '0;
        for (int s = 0; s < NS; s++) begin
            p_w = prio_i[s*PW +: PW];
            if (req_i[s] && ({1'b0, p_w} < ceil_w) && (!win_v_o || (p_w < best_w))) begin
                win_v_o   = 1'b1;
                win_idx_o = IW'(s);
                best_w    = p_w;
            end
        end
    end
endmodule

// File: rtl/pic_merge.sv
module pic_merge
    import pic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NTMR-1:0] tmr_req_i,
    input  logic [NSER-1:0] ser_req_i,
    input  logic [NEXT-1:0] ext_i,
    input  logic            nmi_i,
    input  logic            gmask_i,
    input  logic            ack_i,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   wr_addr_i,
    input  logic [DW-1:0]   wr_data_i,
    output logic            irq_o,
    output logic [VW-1:0]   vec_o,
    output logic            nmi_o,
    output logic [NSRC-1:0] pend_o,
    output logic [NSRC-1:0] insvc_o
);
    localparam int TSW = (NTMR > 1) ? $clog2(NTMR) : 1;
    localparam int SSW = (NSER > 1) ? $clog2(NSER) : 1;

    pic_state_e          state_q, state_d;
    logic [NSRC-1:0]     mask_q;
    logic [NSRC*PW-1:0]  prio_q;
    logic [NEXT-1:0]     mode_q;
    logic [NSRC-1:0]     insvc_q;
    logic [NEXT-1:0]     ext_q, ext_qq;
    logic [VW-1:0]       vec_q;

    logic [NTMR-1:0]     tmr_pend, tmr_clr;
    logic [NSER-1:0]     ser_pend, ser_clr;
    logic [NEXT-1:0]     edge_pend, edge_set, edge_clr, ext_pend;
    logic [NSRC-1:0]     src_pend, req_w, eoi_clr, grant_set;
    logic [TSW-1:0]      tmr_sel;
    logic [SSW-1:0]      ser_sel;
    logic                win_v;
    logic [IW-1:0]       win_idx;
    logic [VW-1:0]       win_vec;
    logic                take, grant;

    // ---------------- request capture ----------------
    assign edge_set = ext_q & ~ext_qq & mode_q;

    pic_pending #(.N(NTMR)) u_tmr_pend (
        .clk(clk), .rst_n(rst_n), .set_i(tmr_req_i), .clr_i(tmr_clr), .pend_o(tmr_pend));
    pic_pending #(.N(NSER)) u_ser_pend (
        .clk(clk), .rst_n(rst_n), .set_i(ser_req_i), .clr_i(ser_clr), .pend_o(ser_pend));
    pic_pending #(.N(NEXT)) u_edge_pend (
        .clk(clk), .rst_n(rst_n), .set_i(edge_set), .clr_i(edge_clr), .pend_o(edge_pend));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q  <= '0;
            ext_qq <= '0;
        end else begin
            ext_q  <= ext_i;
            ext_qq <= ext_q;
        end
    end

    generate
        for (genvar n = 0; n < NEXT; n++) begin : g_ext_mode
            assign ext_pend[n] = mode_q[n] ? edge_pend[n] : ext_q[n];
        end
    endgenerate

    assign src_pend = {ext_pend, |ser_pend, |tmr_pend};
    assign req_w    = src_pend & ~mask_q & {NSRC{~gmask_i}};

    // ---------------- arbitration ----------------
    pic_arbiter #(.NS(NSRC), .PW(PW), .IW(IW)) u_arb (
        .req_i(req_w), .prio_i(prio_q), .insvc_i(insvc_q),
        .win_v_o(win_v), .win_idx_o(win_idx));

    // Lowest-numbered pending event inside each internal group.
    always_comb begin
        tmr_sel = '0;
        for (int k = NTMR-1; k >= 0; k--)
            if (tmr_pend[k]) tmr_sel = TSW'(k);
        ser_sel = '0;
        for (int k = NSER-1; k >= 0; k--)
            if (ser_pend[k]) ser_sel = SSW'(k);
    end

    always_comb begin
        if (win_idx == IW'(SRC_TMR))      win_vec = V_TMR + VW'(tmr_sel);
        else if (win_idx == IW'(SRC_SER)) win_vec = V_SER + VW'(ser_sel);
        else                              win_vec = V_EXT + VW'(win_idx - IW'(SRC_EXT));
    end

    assign take  = (state_q == ST_ASSERT) && ack_i;
    assign grant = take && win_v;

    // ---------------- clears on grant and end-of-interrupt ----------------
    always_comb begin
        tmr_clr   = '0;
        ser_clr   = '0;
        edge_clr  = '0;
        grant_set = '0;
        eoi_clr   = '0;
        if (grant) begin
            grant_set[win_idx] = 1'b1;
            if (win_idx == IW'(SRC_TMR))      tmr_clr[tmr_sel] = 1'b1;
            else if (win_idx == IW'(SRC_SER)) ser_clr[ser_sel] = 1'b1;
            else begin
                for (int n = 0; n < NEXT; n++)
                    if (win_idx == IW'(SRC_EXT + n)) edge_clr[n] = 1'b1;
            end
        end
        if (wr_en_i && (wr_addr_i == A_EOI)) begin
            for (int s = 0; s < NSRC; s++)
                if (wr_data_i[IW-1:0] == IW'(s)) eoi_clr[s] = 1'b1;
        end
    end

    // ---------------- control registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            prio_q <= '1;
            mode_q <= '0;
        end else if (wr_en_i) begin
            unique case (wr_addr_i)
                A_MASK:  mask_q <= wr_data_i[NSRC-1:0];
                A_PRIL:  prio_q[LO_N*PW-1:0] <= wr_data_i[LO_N*PW-1:0];
                A_PRIH:  prio_q[NSRC*PW-1:LO_N*PW] <= wr_data_i[HI_N*PW-1:0];
                A_MODE:  mode_q <= wr_data_i[NEXT-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) insvc_q <= '0;
        else        insvc_q <= (insvc_q & ~eoi_clr) | grant_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    vec_q <= '0;
        else if (take) vec_q <= win_v ? win_vec : V_SPUR;
    end

    // ---------------- state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (win_v) state_d = ST_ASSERT;
            ST_ASSERT: begin
                if (ack_i)       state_d = ST_HOLD;
                else if (!win_v) state_d = ST_IDLE;
            end
            ST_HOLD:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        irq_o   = (state_q == ST_ASSERT);
        vec_o   = vec_q;
        nmi_o   = nmi_i;
        pend_o  = src_pend;
        insvc_o = insvc_q;
    end
endmodule

// File: rtl/pic_merge_chk.sv
module pic_merge_chk
    import pic_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               gmask_i,
    input logic               ack_i,
    input logic               irq_o,
    input logic [VW-1:0]      vec_o,
    input logic [NSRC-1:0]    insvc_q,
    input logic [NSRC-1:0]    mask_q,
    input logic [NSRC*PW-1:0] prio_q,
    input logic               win_v,
    input logic [IW-1:0]      win_idx
);
    logic ceiling_hit;
    always_comb begin
        ceiling_hit = 1'b0;
        for (int j = 0; j < NSRC; j++)
            if (insvc_q[j] && (prio_q[j*PW +: PW] <= prio_q[32'(win_idx)*PW +: PW]))
                ceiling_hit = 1'b1;
    end

    p_gmask_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gmask_i) |-> !irq_o);

    p_allmask_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(&mask_q) |-> !irq_o);

    p_insvc_needs_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(insvc_q & ~$past(insvc_q))) |-> $past(ack_i && irq_o));

    p_vec_needs_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_o != $past(vec_o)) |-> $past(ack_i && irq_o));

    p_nest_ceiling_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_v |-> !ceiling_hit);
endmodule

bind pic_merge pic_merge_chk u_chk (
    .clk(clk), .rst_n(rst_n), .gmask_i(gmask_i), .ack_i(ack_i),
    .irq_o(irq_o), .vec_o(vec_o), .insvc_q(insvc_q), .mask_q(mask_q),
    .prio_q(prio_q), .win_v(win_v), .win_idx(win_idx));

// File: tb/pic_merge_tb.sv
module pic_merge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  tmr_req = '0;
    logic [1:0]  ser_req = '0;
    logic [4:0]  ext = '0;
    logic        nmi = 1'b0, gmask = 1'b0, ack = 1'b0, wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        irq, nmi_out;
    logic [7:0]  vec;
    logic [6:0]  pend, insvc;

    int checks = 0;
    int fails  = 0;
    int pv[7];

    always #4 clk = ~clk;

    pic_merge u_dut (
        .clk(clk), .rst_n(rst_n), .tmr_req_i(tmr_req), .ser_req_i(ser_req),
        .ext_i(ext), .nmi_i(nmi), .gmask_i(gmask), .ack_i(ack),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .irq_o(irq), .vec_o(vec), .nmi_o(nmi_out), .pend_o(pend), .insvc_o(insvc));

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
    endtask

    task automatic prio_apply();
        int lo, hi;
        lo = 0; hi = 0;
        for (int s = 0; s < 5; s++) lo = lo | (pv[s] << (3*s));
        for (int s = 5; s < 7; s++) hi = hi | (pv[s] << (3*(s-5)));
        wr(1, lo);
        wr(2, hi);
    endtask

    task automatic raise(int s);
        if (s == 0) begin tmr_req[0] = 1'b1; tick(1); tmr_req[0] = 1'b0; end
        else if (s == 1) begin ser_req[0] = 1'b1; tick(1); ser_req[0] = 1'b0; end
        else ext[s-2] = 1'b1;
    endtask

    task automatic drop(int s);
        if (s >= 2) ext[s-2] = 1'b0;
    endtask

    function automatic int vexp(int s);
        if (s == 0) return 8;
        if (s == 1) return 12;
        return 16 + s - 2;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 vec", vec, 0);
        chk("R1 pend", pend, 0);
        chk("R1 insvc", insvc, 0);
        // R12 pass-through
        nmi = 1'b1; #1; chk("R12 nmi high", nmi_out, 1);
        nmi = 1'b0; #1; chk("R12 nmi low", nmi_out, 0);

        // R3 / R13: masked pulse stays pending, served once unmasked
        tmr_req[1] = 1'b1; tick(1); tmr_req[1] = 1'b0;
        tick(4);
        chk("R3 masked irq", irq, 0);
        chk("R13 pulse held while masked", pend[0], 1);
        wr(0, 0);
        tick(4);
        chk("R3 unmasked irq", irq, 1);
        do_ack();
        chk("R2 timer1 vector", vec, 9);
        chk("R13 pulse cleared by ack", pend[0], 0);
        wr(4, 0);
        tick(4);

        // Single-source sweep: R2, R7
        for (int k = 0; k < 3; k++) begin
            tmr_req[k] = 1'b1; tick(1); tmr_req[k] = 1'b0;
            tick(4);
            chk("R2 timer irq", irq, 1);
            do_ack();
            chk("R2 timer vector", vec, 8 + k);
            chk("R7 timer insvc", insvc, 1);
            wr(4, 0);
            chk("R7 eoi clears", insvc, 0);
            tick(3);
        end
        for (int k = 0; k < 2; k++) begin
            ser_req[k] = 1'b1; tick(1); ser_req[k] = 1'b0;
            tick(4);
            do_ack();
            chk("R2 serial vector", vec, 12 + k);
            chk("R7 serial insvc", insvc, 2);
            wr(4, 1);
            tick(3);
        end
        for (int n = 0; n < 5; n++) begin
            ext[n] = 1'b1;
            tick(4);
            chk("R2 ext irq", irq, 1);
            do_ack();
            chk("R2 ext vector", vec, 16 + n);
            chk("R7 ext insvc", insvc, 1 << (n + 2));
            ext[n] = 1'b0;
            wr(4, n + 2);
            tick(4);
            chk("R7 ext idle after eoi", irq, 0);
        end

        // R5 / R8 pair sweep over three priority relations
        for (int a = 0; a < 7; a++) begin
            for (int b = a + 1; b < 7; b++) begin
                for (int m = 0; m < 3; m++) begin
                    int pa, pb, w, l;
                    pa = (m == 0) ? 2 : (m == 1) ? 4 : 3;
                    pb = (m == 0) ? 4 : (m == 1) ? 2 : 3;
                    w  = (pb < pa) ? b : a;
                    l  = (w == a) ? b : a;
                    for (int s = 0; s < 7; s++) pv[s] = 7;
                    pv[a] = pa; pv[b] = pb;
                    prio_apply();
                    raise(a); raise(b);
                    tick(4);
                    chk("R5 pair irq", irq, 1);
                    do_ack();
                    chk("R5 pair winner vector", vec, vexp(w));
                    drop(w);
                    tick(4);
                    chk("R8 loser held off", irq, 0);
                    wr(4, w);
                    tick(4);
                    chk("R8 loser after eoi", irq, 1);
                    do_ack();
                    chk("R5 pair loser vector", vec, vexp(l));
                    drop(l);
                    wr(4, l);
                    tick(4);
                end
            end
        end

        // R6 group ordering
        for (int s = 0; s < 7; s++) pv[s] = 7;
        prio_apply();
        tmr_req = 3'b111; tick(1); tmr_req = '0;
        for (int k = 0; k < 3; k++) begin
            tick(4);
            do_ack();
            chk("R6 timer order", vec, 8 + k);
            wr(4, 0);
        end
        ser_req = 2'b11; tick(1); ser_req = '0;
        for (int k = 0; k < 2; k++) begin
            tick(4);
            do_ack();
            chk("R6 serial order", vec, 12 + k);
            wr(4, 1);
        end
        tick(4);

        // R8 nesting: timer=2, ext0=1, ext1=5
        pv[0] = 2; pv[2] = 1; pv[3] = 5;
        prio_apply();
        raise(0); tick(4);
        do_ack();
        chk("R8 first timer", vec, 8);
        ext[1] = 1'b1; tick(5);
        chk("R8 worse blocked", irq, 0);
        ext[0] = 1'b1; tick(4);
        chk("R8 better nests", irq, 1);
        do_ack();
        chk("R8 nested vector", vec, 16);
        ext[0] = 1'b0;
        wr(4, 2); tick(4);
        chk("R8 still under timer", irq, 0);
        wr(4, 0); tick(4);
        chk("R8 released", irq, 1);
        do_ack();
        chk("R8 released vector", vec, 17);
        ext[1] = 1'b0;
        wr(4, 3); tick(4);
        for (int s = 0; s < 7; s++) pv[s] = 7;
        prio_apply();

        // R4 global mask and spurious race (R2)
        gmask = 1'b1;
        ext[0] = 1'b1; tick(5);
        chk("R4 gmask blocks", irq, 0);
        gmask = 1'b0; tick(4);
        chk("R4 gmask released", irq, 1);
        gmask = 1'b1; ack = 1'b1; tick(1); ack = 1'b0;
        chk("R2 spurious vector", vec, 7);
        chk("R2 spurious no insvc", insvc, 0);
        gmask = 1'b0; tick(4);
        do_ack();
        chk("R2 after spurious", vec, 16);
        ext[0] = 1'b0;
        wr(4, 2); tick(4);

        // R11 ack while idle ignored
        chk("R11 idle", irq, 0);
        do_ack(); tick(1);
        chk("R11 vec unchanged", vec, 16);
        chk("R11 insvc unchanged", insvc, 0);

        // R9 level mode
        ext[2] = 1'b1; tick(4);
        chk("R9 level irq", irq, 1);
        ext[2] = 1'b0; tick(4);
        chk("R9 level drop removes", irq, 0);
        chk("R9 level pend gone", pend[4], 0);
        ext[2] = 1'b1; tick(4);
        do_ack();
        chk("R9 level vector", vec, 18);
        wr(4, 4); tick(4);
        chk("R9 level re-request", irq, 1);
        do_ack();
        ext[2] = 1'b0;
        wr(4, 4); tick(4);

        // R10 edge mode on pin 3 (source 5)
        wr(3, 1 << 3);
        ext[3] = 1'b1; tick(2); ext[3] = 1'b0;
        tick(4);
        chk("R10 edge latched", pend[5], 1);
        chk("R10 edge irq", irq, 1);
        do_ack();
        chk("R10 edge vector", vec, 19);
        chk("R10 ack clears latch", pend[5], 0);
        wr(4, 5); tick(4);
        chk("R10 no re-request", irq, 0);
        ext[3] = 1'b1; tick(4);
        do_ack();
        wr(4, 5); tick(5);
        chk("R10 held pin no retrigger", irq, 0);
        ext[3] = 1'b0;
        wr(3, 0); tick(4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule